// File: doc/BRIEF.md
# Bus-Vectored Interrupt Acknowledge Sequencer

This block runs the two-cycle interrupt acknowledge handshake for a processor whose master interrupt controller cascades to slave controllers on a shared system bus. When the processor's decoded status shows an acknowledge cycle, the block requests the bus from an arbiter. Once the grant arrives it strobes the bus acknowledge, so the slave controllers freeze their priority state. It also acknowledges the master controller locally, and the master then puts the slave ID on the cascade lines. The first cycle is completed by READY from a late timing tap of the processor bus cycle.

At the start of the second acknowledge cycle the block captures the cascade ID and places it on bus address bits 8 to 10. In bus-vectored mode it opens the data buffers for a byte-wide inbound transfer and waits for the remote transfer acknowledge to produce READY. In local-vectored mode the master controller supplies the vector, and READY comes from its data enable together with the late tap. A failsafe timeout input can complete either cycle. After the second READY the bus request drops and the block waits for the next sequence.

Top module: `iack_seq`

## Requirements
- R1: During reset and on the first clock after reset release, every output is low and bus_adr_o is 0.
- R2: bus_req_o rises on the clock after ack_cyc_i is first seen high in idle. bus_ack_stb_o stays low until bus_grant_i has been sampled high, and rises on the clock after that.
- R3: Throughout the first acknowledge cycle, once the grant is in, both bus_ack_stb_o and lcl_ack_o are high in either mode.
- R4: READY for the first cycle is a one-clock pulse on the clock after late_tap_i is sampled high with the strobe active. bus_xack_i has no effect on it.
- R5: The clock on which ack_cyc_i rises again for the second cycle captures cas_id_i. bus_adr_o (address bits 8 to 10, bit 0 = address bit 8) shows that value from the next clock until the second READY and is 0 at all other times. Later changes of cas_id_i do not alter it.
- R6: When bus_vec_mode_i is 1, READY for the second cycle follows one clock after bus_xack_i is sampled high with bus_grant_i high. late_tap_i alone does not produce it, and bus_ack_stb_o is high during that cycle.
- R7: When bus_vec_mode_i is 0, READY for the second cycle follows one clock after lcl_den_i and late_tap_i are sampled high together. bus_xack_i alone does not produce it, bus_ack_stb_o is low and lcl_ack_o is high during that cycle.
- R8: buf_byte_o and buf_rx_o are high only during a bus-vectored second acknowledge cycle.
- R9: tmo_i sampled high while the strobe of either acknowledge cycle is active produces READY on the next clock in both modes.
- R10: bus_req_o falls on the same clock that the second READY pulse rises, and it is not raised again until ack_cyc_i has gone low and then high.
- R11: Each acknowledge cycle yields exactly one READY pulse, one clock wide. No READY appears at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_cyc_i | input | 1 | Decoded processor status: acknowledge bus cycle in progress |
| late_tap_i | input | 1 | Late-state timing tap of the processor bus cycle |
| lcl_den_i | input | 1 | Master controller data enable (local vector) |
| cas_id_i | input | 3 | Slave ID from the master controller's cascade lines |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| bus_xack_i | input | 1 | Bus transfer acknowledge from the slave |
| bus_vec_mode_i | input | 1 | Mode strap: 1 bus-vectored, 0 local-vectored |
| tmo_i | input | 1 | Failsafe timeout |
| bus_req_o | output | 1 | Bus arbitration request |
| bus_ack_stb_o | output | 1 | Acknowledge strobe onto the system bus |
| lcl_ack_o | output | 1 | Local acknowledge to the master controller |
| bus_adr_o | output | 3 | Latched slave ID on bus address bits 8 to 10 |
| buf_byte_o | output | 1 | Data buffers set to byte width |
| buf_rx_o | output | 1 | Data buffers set to inbound direction |
| ready_o | output | 1 | READY to the processor |

## Verification
Every result is due one clock after the input that causes it is sampled. This holds for the request after status, the strobe after grant, the address after the second status rise, and READY after the tap, transfer acknowledge, data enable or timeout. The driver changes inputs on the falling edge and checks outputs on the next falling edge, which lands exactly half a cycle after the register update. Before raising each READY cause, the driver queues the expected pulse with the bus request level it must see. A monitor on the falling edge pops one entry per pulse, so an early, extra or doubled pulse is caught at once. For each input that must be ignored, the bench holds it for two clocks and checks that no READY appears.

// File: rtl/iack_pkg.sv
package iack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB1,
    ST_CYC1,
    ST_GAP,
    ST_MID,
    ST_ARB2,
    ST_CYC2,
    ST_DONE
  } iack_st_e;
endpackage

// File: rtl/iack_rst_sync.sv
module iack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/iack_fsm.sv
module iack_fsm
  import iack_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ack_cyc_i,
  input  logic     grant_i,
  input  logic     hit_i,
  output iack_st_e st_o,
  output logic     load_o
);
  iack_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ack_cyc_i) st_d = ST_ARB1;
      ST_ARB1: if (grant_i)   st_d = ST_CYC1;
      ST_CYC1: if (hit_i)     st_d = ST_GAP;
      ST_GAP:  if (!ack_cyc_i) st_d = ST_MID;
      ST_MID:  if (ack_cyc_i) st_d = grant_i ? ST_CYC2 : ST_ARB2;
      ST_ARB2: if (grant_i)   st_d = ST_CYC2;
      ST_CYC2: if (hit_i)     st_d = ST_DONE;
      ST_DONE: if (!ack_cyc_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o   = st_q;
  assign load_o = (st_q == ST_MID) && ack_cyc_i;
endmodule

// File: rtl/iack_casid_latch.sv
module iack_casid_latch #(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            drive_i,
  input  logic [ID_W-1:0] id_i,
  output logic [ID_W-1:0] adr_o
);
  logic [ID_W-1:0] id_q, id_d;

  always_comb begin
    id_d = id_q;
    if (load_i) id_d = id_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_q <= '0;
    else        id_q <= id_d;
  end

  assign adr_o = drive_i ? id_q : '0;
endmodule

// File: rtl/iack_ready_gen.sv
module iack_ready_gen
  import iack_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  iack_st_e st_i,
  input  logic     late_tap_i,
  input  logic     lcl_den_i,
  input  logic     xack_i,
  input  logic     grant_i,
  input  logic     bus_mode_i,
  input  logic     tmo_i,
  output logic     hit_o,
  output logic     ready_o
);
  logic second_ok;
  logic ready_q, ready_d;

  always_comb begin
    if (bus_mode_i) second_ok = xack_i && grant_i;
    else            second_ok = lcl_den_i && late_tap_i;
  end

  always_comb begin
    hit_o = 1'b0;
    unique case (st_i)
      ST_CYC1: hit_o = late_tap_i || tmo_i;
      ST_CYC2: hit_o = second_ok || tmo_i;
      default: hit_o = 1'b0;
    endcase
  end

  always_comb ready_d = hit_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
#(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_cyc_i,
  input  logic            late_tap_i,
  input  logic            lcl_den_i,
  input  logic [ID_W-1:0] cas_id_i,
  input  logic            bus_grant_i,
  input  logic            bus_xack_i,
  input  logic            bus_vec_mode_i,
  input  logic            tmo_i,
  output logic            bus_req_o,
  output logic            bus_ack_stb_o,
  output logic            lcl_ack_o,
  output logic [ID_W-1:0] bus_adr_o,
  output logic            buf_byte_o,
  output logic            buf_rx_o,
  output logic            ready_o
);
  logic     rst_i_n;
  iack_st_e st;
  logic     hit;
  logic     load_id;
  logic     in_c1, in_c2, in_seq;

  iack_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  iack_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ack_cyc_i(ack_cyc_i),
    .grant_i  (bus_grant_i),
    .hit_i    (hit),
    .st_o     (st),
    .load_o   (load_id)
  );

  iack_ready_gen u_rdy (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .st_i      (st),
    .late_tap_i(late_tap_i),
    .lcl_den_i (lcl_den_i),
    .xack_i    (bus_xack_i),
    .grant_i   (bus_grant_i),
    .bus_mode_i(bus_vec_mode_i),
    .tmo_i     (tmo_i),
    .hit_o     (hit),
    .ready_o   (ready_o)
  );

  iack_casid_latch #(.ID_W(ID_W)) u_id (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load_i (load_id),
    .drive_i(st == ST_ARB2 || st == ST_CYC2),
    .id_i   (cas_id_i),
    .adr_o  (bus_adr_o)
  );

  always_comb begin
    in_c1  = (st == ST_CYC1);
    in_c2  = (st == ST_CYC2);
    in_seq = (st != ST_IDLE) && (st != ST_DONE);
  end

  assign bus_req_o     = in_seq;
  assign bus_ack_stb_o = in_c1 || (in_c2 && bus_vec_mode_i);
  assign lcl_ack_o     = in_c1 || (in_c2 && !bus_vec_mode_i);
  assign buf_byte_o    = in_c2 && bus_vec_mode_i;
  assign buf_rx_o      = in_c2 && bus_vec_mode_i;
endmodule

// File: rtl/iack_seq_chk.sv
module iack_seq_chk #(
  parameter int ID_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            late_tap_i,
  input logic            lcl_den_i,
  input logic            bus_grant_i,
  input logic            bus_xack_i,
  input logic            tmo_i,
  input logic            bus_req_o,
  input logic            bus_ack_stb_o,
  input logic            lcl_ack_o,
  input logic [ID_W-1:0] bus_adr_o,
  input logic            buf_rx_o,
  input logic            ready_o
);
  // R1
  always_comb if (!rst_n) reset_quiet_chk: assert (ready_o == 1'b0 || $isunknown(ready_o));

  // R2
  strobe_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_stb_o) |-> $past(bus_grant_i));

  // R11
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  // R10
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_o) |-> ready_o);

  // R4
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(late_tap_i || tmo_i || bus_xack_i || lcl_den_i));

  // R5
  adr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_adr_o != '0) |=> (bus_adr_o == $past(bus_adr_o)) || (bus_adr_o == '0));

  // R8
  buf_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rx_o |-> bus_req_o);

  // R3
  local_ack_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_ack_o |-> bus_req_o);
endmodule

bind iack_seq iack_seq_chk #(.ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .late_tap_i   (late_tap_i),
  .lcl_den_i    (lcl_den_i),
  .bus_grant_i  (bus_grant_i),
  .bus_xack_i   (bus_xack_i),
  .tmo_i        (tmo_i),
  .bus_req_o    (bus_req_o),
  .bus_ack_stb_o(bus_ack_stb_o),
  .lcl_ack_o    (lcl_ack_o),
  .bus_adr_o    (bus_adr_o),
  .buf_rx_o     (buf_rx_o),
  .ready_o      (ready_o)
);

// File: tb/tb_iack_seq.sv
`timescale 1ns/1ps
module tb_iack_seq;
  logic       clk;
  logic       rst_n;
  logic       ack_cyc, late_tap, lcl_den, grant, xack, vmode, tmo;
  logic [2:0] cas_id;
  logic       bus_req, stb, lcl_ack, buf_byte, buf_rx, ready;
  logic [2:0] bus_adr;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  bit exp_q[$];
  logic prev_ready = 1'b0;

  iack_seq dut (
    .clk(clk), .rst_n(rst_n), .ack_cyc_i(ack_cyc), .late_tap_i(late_tap),
    .lcl_den_i(lcl_den), .cas_id_i(cas_id), .bus_grant_i(grant),
    .bus_xack_i(xack), .bus_vec_mode_i(vmode), .tmo_i(tmo),
    .bus_req_o(bus_req), .bus_ack_stb_o(stb), .lcl_ack_o(lcl_ack),
    .bus_adr_o(bus_adr), .buf_byte_o(buf_byte), .buf_rx_o(buf_rx),
    .ready_o(ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one queued entry per READY pulse, holding the expected bus_req level
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (ready) begin
        if (prev_ready) chk("R11 pulse width", 8'd2, 8'd1);
        else if (exp_q.size() == 0) chk("R11 unexpected ready", 8'd1, 8'd0);
        else begin
          bit e;
          e = exp_q.pop_front();
          chk("R10 bus_req at ready", {7'd0, bus_req}, {7'd0, e});
        end
      end
      prev_ready = ready;
    end
  end

  task automatic run_seq(input bit mode, input logic [2:0] id, input int gdly,
                         input bit tmo1, input bit tmo2);
    vmode = mode; cas_id = id; ack_cyc = 1'b1;
    @(negedge clk);
    chk("R2 req raised", {7'd0, bus_req}, 8'd1);
    chk("R2 no strobe before grant", {7'd0, stb}, 8'd0);
    for (int i = 0; i < gdly; i++) begin
      @(negedge clk);
      chk("R2 no strobe while waiting", {7'd0, stb}, 8'd0);
    end
    grant = 1'b1;
    @(negedge clk);
    chk("R3 bus strobe cycle1", {7'd0, stb}, 8'd1);
    chk("R3 local ack cycle1", {7'd0, lcl_ack}, 8'd1);
    chk("R8 buffers idle cycle1", {6'd0, buf_byte, buf_rx}, 8'd0);
    chk("R5 adr zero cycle1", {5'd0, bus_adr}, 8'd0);
    // R4: transfer acknowledge ignored in the first cycle
    xack = 1'b1;
    @(negedge clk); @(negedge clk);
    xack = 1'b0;
    chk("R4 xack ignored", {7'd0, ready}, 8'd0);
    exp_q.push_back(1'b1);
    if (tmo1) tmo = 1'b1; else late_tap = 1'b1;
    @(negedge clk);
    tmo = 1'b0; late_tap = 1'b0;
    chk(tmo1 ? "R9 timeout ready cycle1" : "R4 ready cycle1", {7'd0, ready}, 8'd1);
    ack_cyc = 1'b0;
    @(negedge clk);
    chk("R11 ready cleared", {7'd0, ready}, 8'd0);
    @(negedge clk);
    chk("R10 req held between cycles", {7'd0, bus_req}, 8'd1);
    ack_cyc = 1'b1;
    @(negedge clk);
    cas_id = ~id;
    chk("R5 adr latched", {5'd0, bus_adr}, {5'd0, id});
    chk("R8 byte width", {7'd0, buf_byte}, {7'd0, mode});
    chk("R8 inbound", {7'd0, buf_rx}, {7'd0, mode});
    chk(mode ? "R6 bus strobe cycle2" : "R7 no bus strobe cycle2", {7'd0, stb}, {7'd0, mode});
    chk("R7 local ack cycle2", {7'd0, lcl_ack}, {7'd0, !mode});
    // ignored causes for this mode
    if (mode) late_tap = 1'b1; else xack = 1'b1;
    @(negedge clk); @(negedge clk);
    late_tap = 1'b0; xack = 1'b0;
    chk(mode ? "R6 tap alone ignored" : "R7 xack ignored", {7'd0, ready}, 8'd0);
    chk("R5 adr held after cas change", {5'd0, bus_adr}, {5'd0, id});
    exp_q.push_back(1'b0);
    if (tmo2) tmo = 1'b1;
    else if (mode) xack = 1'b1;
    else begin lcl_den = 1'b1; late_tap = 1'b1; end
    @(negedge clk);
    tmo = 1'b0; xack = 1'b0; lcl_den = 1'b0; late_tap = 1'b0;
    chk(tmo2 ? "R9 timeout ready cycle2" : (mode ? "R6 ready cycle2" : "R7 ready cycle2"),
        {7'd0, ready}, 8'd1);
    chk("R10 req released", {7'd0, bus_req}, 8'd0);
    chk("R5 adr cleared", {5'd0, bus_adr}, 8'd0);
    @(negedge clk);
    chk("R10 no request while status high", {7'd0, bus_req}, 8'd0);
    ack_cyc = 1'b0; grant = 1'b0;
    @(negedge clk);
    chk("R11 no ready after sequence", {7'd0, ready}, 8'd0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ack_cyc = 0; late_tap = 0; lcl_den = 0; grant = 0;
    xack = 0; vmode = 0; tmo = 0; cas_id = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {bus_req, stb, lcl_ack, buf_byte, buf_rx, ready, 2'b0}, 8'd0);
    chk("R1 reset adr", {5'd0, bus_adr}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {bus_req, stb, lcl_ack, buf_byte, buf_rx, ready, 2'b0}, 8'd0);
    repeat (4) @(negedge clk);
    run_seq(1'b1, 3'd5, 2, 1'b0, 1'b0);
    run_seq(1'b0, 3'd3, 0, 1'b0, 1'b0);
    run_seq(1'b1, 3'd6, 1, 1'b0, 1'b1);
    run_seq(1'b0, 3'd2, 3, 1'b1, 1'b0);
    run_seq(1'b1, 3'd7, 0, 1'b1, 1'b0);
    chk("R11 all pulses seen", exp_q.size()[7:0], 8'd0);
    finish_run();
  end
endmodule